// File: doc/BRIEF.md
# Status Register and Write-Lock Arbiter for a Serial Memory

This block keeps the eight-bit status register of a serial nonvolatile memory and decides, cycle by cycle, whether a write may go ahead. The serial command decoder sends it single-cycle events: write-enable set, write-enable clear, a captured status-register data byte, a write-cycle start (for the status register or for the array) and write-cycle completion. The block also sees the board's write-protect pin and whether the chip is currently selected. It returns the byte that a status read shifts out, a permit for an array write at a given address, a permit for a status write, and a busy flag.

Array protection has eight levels, chosen by a three-bit lock code. The code can protect nothing, the top quarter, the top half or the whole array, or the first one, two, four or eight pages counted from address zero. A separate protect-enable bit arms the write-protect pin. When the pin is low and that bit is set, no status-register write is accepted, so the protect-enable bit cannot be cleared while the pin stays low. Array lock ranges apply whatever the pin level.

A status write is staged when its data byte arrives. It is cancelled if hardware protection becomes active while the chip is still selected. Otherwise it becomes a write cycle when the decoder signals the start, and it updates the register when the cycle completes. Nonvolatile bits are ordinary flops, cleared by reset.

Top module: `sr_blocklock`

## Requirements
- R1: The status byte is {protect_en, 0, 0, lock[2:0], wr_en, in_progress}, with bit 7 the protect-enable bit, bits 6 and 5 always 0, bits 4..2 the lock code, bit 1 the write-enable flag and bit 0 the in-progress flag. After reset the byte is 0x00.
- R2: A write-enable event sets bit 1 and a write-enable clear event clears it, in both cases one clock edge later.
- R3: A completed status write changes only bit 7 and bits 4..2, taken from data bits 7 and 4..2. Data bits 6, 5, 1 and 0 have no effect. Those fields change only when a status write cycle completes.
- R4: For each lock code, `arr_permit` is low for the addresses the code protects, while write-enable is set and no cycle is running. Code 000 protects nothing. Code 001 protects 0x6000-0x7FFF, code 010 protects 0x4000-0x7FFF and code 011 protects the whole array. Codes 100, 101, 110 and 111 protect 0x0000-0x003F, 0x0000-0x007F, 0x0000-0x00FF and 0x0000-0x01FF respectively.
- R5: A start request that is refused leaves the in-progress flag low and the write-enable flag unchanged. A request is refused when write-enable is clear, when the address is locked, or when a status start has no staged data.
- R6: An accepted start sets busy on the next edge, and while busy the status byte reads 0xFF.
- R7: A completion event during a cycle clears busy and the write-enable flag on the next edge.
- R8: When the write-protect pin is low and the protect-enable bit is 1, `sr_permit` is low and status data bytes are ignored. When the pin is high or the bit is 0, status writes are permitted if write-enable is set.
- R9: The array lock decision does not depend on the write-protect pin.
- R10: A staged status write is discarded if the pin goes low, with the protect-enable bit set, while the chip is still selected. Once its cycle has started, the pin has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, standing in for power-up |
| wp_pin | input | 1 | Write-protect pin, low = protect when armed |
| cs_active | input | 1 | High while the chip is selected |
| ev_wren | input | 1 | Write-enable set event |
| ev_wrdi | input | 1 | Write-enable clear event |
| ev_sr_data | input | 1 | Status data byte captured |
| sr_data | input | 8 | Captured status data byte |
| chk_addr | input | 15 | Array address to check / to start writing |
| ev_start | input | 1 | Write-cycle start request |
| start_status | input | 1 | With ev_start: 1 = status cycle, 0 = array cycle |
| ev_done | input | 1 | Write-cycle completion |
| status_byte | output | 8 | Byte returned by a status read |
| arr_permit | output | 1 | Array write to chk_addr allowed |
| sr_permit | output | 1 | Status write allowed |
| busy | output | 1 | Write cycle in progress |

## Verification
Every event reaches the state flops at the next rising edge, so the status byte and busy are due one edge after the cycle in which the event was driven. The two permits are combinational from that state and from the address and pin, so they are due in the same cycle as a change of `chk_addr` or `wp_pin`. The driver applies each stimulus on a falling edge and queues the expected value tagged with the cycle number of the following rising edge. The monitor compares shortly after that edge, while no other input is moving. Lock boundaries are checked on both sides of every range edge, for all eight codes.

// File: rtl/sr_blocklock_pkg.sv
package sr_blocklock_pkg;

    localparam int SR_W      = 8;
    localparam int LOCK_W    = 3;
    localparam int NVBITS_W  = LOCK_W + 1;

    // Bit positions the serial read path depends on.
    localparam int POS_PEN   = 7;
    localparam int POS_LOCKH = 4;
    localparam int POS_LOCKL = 2;
    localparam int POS_WEN   = 1;
    localparam int POS_PROG  = 0;

    typedef struct packed {
        logic                protect_en;
        logic [LOCK_W-1:0]   lock;
        logic                wr_en;
        logic                in_prog;
        logic                staged;
        logic                cyc_is_sr;
        logic [NVBITS_W-1:0] staged_bits;
    } sr_state_t;

endpackage

// File: rtl/sr_lock_map.sv
module sr_lock_map #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic [2:0]        code_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    localparam int PIDX_W = ADDR_W - PAGE_W;

    logic [PIDX_W-1:0] page_idx;
    logic [PIDX_W-1:0] low_limit;

    assign page_idx  = addr_i[ADDR_W-1:PAGE_W];
    assign low_limit = PIDX_W'(1) << code_i[1:0];

    always_comb begin
        case (code_i)
            3'b000:  locked_o = 1'b0;
            3'b001:  locked_o = addr_i[ADDR_W-1] & addr_i[ADDR_W-2];
            3'b010:  locked_o = addr_i[ADDR_W-1];
            3'b011:  locked_o = 1'b1;
            default: locked_o = (page_idx < low_limit);
        endcase
    end
endmodule

// File: rtl/sr_wp_gate.sv
module sr_wp_gate (
    input  logic wp_pin_i,
    input  logic protect_en_i,
    input  logic staged_i,
    input  logic cs_active_i,
    output logic hw_prot_o,
    output logic cancel_o
);
    always_comb begin
        hw_prot_o = ~wp_pin_i & protect_en_i;
        cancel_o  = staged_i & cs_active_i & hw_prot_o;
    end
endmodule

// File: rtl/sr_state_regs.sv
module sr_state_regs
    import sr_blocklock_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_wren_i,
    input  logic            ev_wrdi_i,
    input  logic            ev_sr_data_i,
    input  logic [SR_W-1:0] sr_data_i,
    input  logic            ev_start_i,
    input  logic            start_status_i,
    input  logic            ev_done_i,
    input  logic            locked_i,
    input  logic            hw_prot_i,
    input  logic            cancel_i,
    output sr_state_t       state_o
);
    sr_state_t st_d, st_q;
    logic      sr_ok;

    always_comb begin
        st_d  = st_q;
        sr_ok = st_q.wr_en & ~st_q.in_prog & ~hw_prot_i;

        if (ev_wren_i && !st_q.in_prog) st_d.wr_en = 1'b1;
        if (ev_wrdi_i && !st_q.in_prog) st_d.wr_en = 1'b0;

        if (ev_sr_data_i && sr_ok) begin
            st_d.staged      = 1'b1;
            st_d.staged_bits = {sr_data_i[POS_PEN], sr_data_i[POS_LOCKH:POS_LOCKL]};
        end
        if (cancel_i) st_d.staged = 1'b0;

        if (ev_start_i && !st_q.in_prog) begin
            st_d.staged = 1'b0;
            if (start_status_i) begin
                if (st_q.staged && sr_ok && !cancel_i) begin
                    st_d.in_prog   = 1'b1;
                    st_d.cyc_is_sr = 1'b1;
                end
            end else if (st_q.wr_en && !locked_i) begin
                st_d.in_prog   = 1'b1;
                st_d.cyc_is_sr = 1'b0;
            end
        end

        if (ev_done_i && st_q.in_prog) begin
            st_d.in_prog = 1'b0;
            st_d.wr_en   = 1'b0;
            if (st_q.cyc_is_sr) {st_d.protect_en, st_d.lock} = st_q.staged_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state_o = st_q;

    // R3: non-volatile fields move only on completion of a cycle
    p_nv_only_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_done_i && st_q.in_prog) |=> ($stable(st_q.lock) && $stable(st_q.protect_en)));

    // R6: a cycle begins only in answer to a start request
    p_start_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.in_prog) |-> $past(ev_start_i));

    // R10: a cancelled staging does not survive
    p_cancel_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_i && !ev_sr_data_i) |=> !st_q.staged);
endmodule

// File: rtl/sr_blocklock.sv
module sr_blocklock
    import sr_blocklock_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin,
    input  logic              cs_active,
    input  logic              ev_wren,
    input  logic              ev_wrdi,
    input  logic              ev_sr_data,
    input  logic [7:0]        sr_data,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              ev_start,
    input  logic              start_status,
    input  logic              ev_done,
    output logic [7:0]        status_byte,
    output logic              arr_permit,
    output logic              sr_permit,
    output logic              busy
);
    sr_state_t st;
    logic      locked, hw_prot, cancel;

    sr_lock_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
        .code_i   (st.lock),
        .addr_i   (chk_addr),
        .locked_o (locked)
    );

    sr_wp_gate u_gate (
        .wp_pin_i     (wp_pin),
        .protect_en_i (st.protect_en),
        .staged_i     (st.staged),
        .cs_active_i  (cs_active),
        .hw_prot_o    (hw_prot),
        .cancel_o     (cancel)
    );

    sr_state_regs u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_wren_i      (ev_wren),
        .ev_wrdi_i      (ev_wrdi),
        .ev_sr_data_i   (ev_sr_data),
        .sr_data_i      (sr_data),
        .ev_start_i     (ev_start),
        .start_status_i (start_status),
        .ev_done_i      (ev_done),
        .locked_i       (locked),
        .hw_prot_i      (hw_prot),
        .cancel_i       (cancel),
        .state_o        (st)
    );

    always_comb begin
        status_byte = '0;
        if (st.in_prog) begin
            status_byte = '1;
        end else begin
            status_byte[POS_PEN]             = st.protect_en;
            status_byte[POS_LOCKH:POS_LOCKL] = st.lock;
            status_byte[POS_WEN]             = st.wr_en;
        end
        arr_permit = st.wr_en & ~st.in_prog & ~locked;
        sr_permit  = st.wr_en & ~st.in_prog & ~hw_prot;
        busy       = st.in_prog;
    end

    // R1: unused bits read back as zero outside a cycle
    p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (status_byte[6:5] == 2'b00));

    // R4: whole-array code refuses every address
    p_whole_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && status_byte[4:2] == 3'b011) |-> !arr_permit);

    // R5: a refused array start leaves the flags alone
    p_refused_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !start_status && !busy && !arr_permit && !ev_wren && !ev_wrdi)
        |=> (!busy && status_byte[1] == $past(status_byte[1])));

    // R7: completion clears busy and write enable
    p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ev_done) |=> (!busy && !status_byte[1]));

    // R8: armed pin blocks status writes
    p_hw_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_pin && !busy && status_byte[7]) |-> !sr_permit);
endmodule

// File: tb/sr_blocklock_tb_top.sv
module sr_blocklock_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_pin = 1'b1, cs_active = 1'b0;
    logic        ev_wren = 1'b0, ev_wrdi = 1'b0, ev_sr_data = 1'b0;
    logic [7:0]  sr_data = '0;
    logic [14:0] chk_addr = '0;
    logic        ev_start = 1'b0, start_status = 1'b0, ev_done = 1'b0;
    logic [7:0]  status_byte;
    logic        arr_permit, sr_permit, busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_blocklock dut_i (
        .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .cs_active(cs_active),
        .ev_wren(ev_wren), .ev_wrdi(ev_wrdi), .ev_sr_data(ev_sr_data),
        .sr_data(sr_data), .chk_addr(chk_addr), .ev_start(ev_start),
        .start_status(start_status), .ev_done(ev_done),
        .status_byte(status_byte), .arr_permit(arr_permit),
        .sr_permit(sr_permit), .busy(busy)
    );

    typedef struct {
        int         due;
        int         fld;   // 0 status_byte, 1 arr_permit, 2 sr_permit, 3 busy
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int cyc = 0, checks = 0, failures = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc++;

    // Monitor: compares queued expectations shortly after their edge
    always @(posedge clk) begin
        #2;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            sb_item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.fld)
                0:       act = status_byte;
                1:       act = {7'b0, arr_permit};
                2:       act = {7'b0, sr_permit};
                default: act = {7'b0, busy};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s field=%0d actual=0x%02h expected=0x%02h",
                         it.req, it.fld, act, it.exp);
            end
        end
    end

    task automatic expect_sb(input int fld, input logic [7:0] exp, input string req);
        sb_item_t it;
        it.due = cyc + 1; it.fld = fld; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic wait_edge();
        @(negedge clk);
    endtask

    task automatic do_wren();
        ev_wren = 1'b1; wait_edge(); ev_wren = 1'b0;
    endtask

    task automatic do_wrdi();
        ev_wrdi = 1'b1; wait_edge(); ev_wrdi = 1'b0;
    endtask

    task automatic do_stage(input logic [7:0] d);
        sr_data = d; ev_sr_data = 1'b1; wait_edge(); ev_sr_data = 1'b0;
    endtask

    task automatic do_start(input logic is_sr);
        start_status = is_sr; ev_start = 1'b1; wait_edge();
        ev_start = 1'b0; start_status = 1'b0;
    endtask

    task automatic do_done();
        ev_done = 1'b1; wait_edge(); ev_done = 1'b0;
    endtask

    task automatic drain();
        repeat (3) wait_edge();
    endtask

    // Full status write: enable, stage, start, finish
    task automatic write_sr(input logic [7:0] d, input logic [7:0] exp_after);
        do_wren();
        cs_active = 1'b1; do_stage(d); cs_active = 1'b0;
        do_start(1'b1);
        expect_sb(3, 8'h01, "R6 busy after status start");
        expect_sb(0, 8'hFF, "R6 read all ones while busy");
        drain();
        do_done();
        expect_sb(0, exp_after, "R3 status after write completes");
        expect_sb(3, 8'h00, "R7 busy cleared");
        drain();
    endtask

    function automatic bit tb_locked(input int code, input int a);
        case (code)
            0: return 1'b0;
            1: return a >= 'h6000;
            2: return a >= 'h4000;
            3: return 1'b1;
            4: return a < 'h40;
            5: return a < 'h80;
            6: return a < 'h100;
            default: return a < 'h200;
        endcase
    endfunction

    int edges[14] = '{'h0000, 'h003F, 'h0040, 'h007F, 'h0080, 'h00FF, 'h0100,
                      'h01FF, 'h0200, 'h3FFF, 'h4000, 'h5FFF, 'h6000, 'h7FFF};

    initial begin
        repeat (3) wait_edge();
        rst_n = 1'b1;
        wait_edge();
        // R1 reset state
        chk_addr = 15'h0100;
        expect_sb(0, 8'h00, "R1 reset byte");
        expect_sb(3, 8'h00, "R1 reset busy");
        expect_sb(2, 8'h00, "R8 no status permit without enable");
        drain();

        // R5 refused array start with write enable clear
        do_start(1'b0);
        expect_sb(3, 8'h00, "R5 no cycle without enable");
        expect_sb(0, 8'h00, "R5 flags unchanged");
        drain();

        // R2 enable set/clear
        do_wren();
        expect_sb(0, 8'h02, "R2 enable set");
        expect_sb(2, 8'h01, "R8 status permit with pin high");
        expect_sb(1, 8'h01, "R4 code 000 permits");
        drain();
        do_wrdi();
        expect_sb(0, 8'h00, "R2 enable cleared");
        drain();

        // R3 junk bits ignored: 0xFF gives protect_en=1, lock=111
        write_sr(8'hFF, 8'h9C);

        // R8/R9 with pin low and protection armed
        do_wren();
        wp_pin = 1'b0;
        chk_addr = 15'h01FF;
        expect_sb(0, 8'h9E, "R2 enable set again");
        expect_sb(2, 8'h00, "R8 pin low blocks status write");
        expect_sb(1, 8'h00, "R9 locked page refused with pin low");
        drain();
        chk_addr = 15'h0200;
        expect_sb(1, 8'h01, "R9 unlocked address allowed with pin low");
        drain();
        cs_active = 1'b1; do_stage(8'h00); cs_active = 1'b0;
        do_start(1'b1);
        expect_sb(3, 8'h00, "R8 blocked status start refused");
        expect_sb(0, 8'h9E, "R8 register unchanged");
        drain();
        chk_addr = 15'h01C0;
        do_start(1'b0);
        expect_sb(3, 8'h00, "R5 locked start refused");
        expect_sb(0, 8'h9E, "R5 enable kept");
        drain();
        chk_addr = 15'h0200;
        do_start(1'b0);
        expect_sb(0, 8'hFF, "R6 array cycle busy read");
        drain();
        do_done();
        expect_sb(0, 8'h9C, "R7 enable cleared after array cycle");
        drain();
        wp_pin = 1'b1;

        // R4 every code, both sides of each boundary
        for (int code = 0; code < 8; code++) begin
            logic [7:0] d, e;
            d = {1'b0, 2'b11, code[2:0], 2'b11};
            e = {1'b0, 2'b00, code[2:0], 2'b00};
            write_sr(d, e);
            do_wren();
            drain();
            for (int k = 0; k < 14; k++) begin
                chk_addr = edges[k][14:0];
                expect_sb(1, {7'b0, ~tb_locked(code, edges[k])}, "R4 lock map");
                wait_edge();
            end
            do_wrdi();
            drain();
        end

        // R10 cancel while selected
        write_sr(8'h80, 8'h80);
        do_wren();
        cs_active = 1'b1; do_stage(8'h00);
        wp_pin = 1'b0; wait_edge(); wp_pin = 1'b1;
        cs_active = 1'b0;
        do_start(1'b1);
        expect_sb(3, 8'h00, "R10 cancelled write does not start");
        expect_sb(0, 8'h82, "R10 register kept");
        drain();
        // R10 pin low after start has no effect
        cs_active = 1'b1; do_stage(8'h00); cs_active = 1'b0;
        do_start(1'b1);
        wp_pin = 1'b0;
        expect_sb(3, 8'h01, "R10 cycle running");
        drain();
        do_done();
        expect_sb(0, 8'h00, "R10 write applied despite pin low");
        drain();
        wp_pin = 1'b1;
        drain();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule